// File: doc/BRIEF.md
# Converter Test Pattern Generator

This block produces one digital test word per sample for the output path of a data converter. Two sources are available. The first is a 23-bit linear feedback shift register that generates a pseudo-random bit sequence. The second is a 16-bit two's-complement ramp. A trigger pulse restarts both sources from known values. At the same moment it captures which source to use and which output width to use, so the stream never changes character partway through.

The 16-bit pattern word can go out unchanged. It can also be cut down to 14 bits by a rounding stage. That stage adds the highest discarded bit to the kept bits, and it saturates at positive full scale instead of wrapping to the negative extreme. A receiver that checks the pattern must copy this rounding step. Simple truncation gives a stream that disagrees with the block near the positive limit and at every other rounding point. The 14-bit result sits right-aligned in the 16-bit output, and the two upper bits are zero.

Top module: `conv_test_pattern_gen`

## Requirements
- R1: After reset the block selects the pseudo-random source in 16-bit width, the shift register holds all ones and the ramp holds 0x0000, so `pattern_out` reads 0xFFFF.
- R2: A clock edge with `trigger` high loads all 23 shift-register bits with 1 and clears the ramp to 0x0000, even when `sample_en` is also high; from the next cycle the output shows that seed value (or zero for the ramp), formatted for the captured width.
- R3: Each clock edge with `sample_en` high and `trigger` low shifts the register one place toward its MSB, and the new bit 0 is the XOR of state bits 22 and 17 (polynomial x^23 + x^18 + 1).
- R4: With `pattern_sel` = 0 (pseudo-random) captured and `narrow_mode` = 0, `pattern_out` equals shift-register bits [15:0].
- R5: With `pattern_sel` = 1 (ramp) captured, the ramp advances by one on each enabled sample and wraps from 0xFFFF to 0x0000 after 65536 samples.
- R6: When neither `sample_en` nor `trigger` is high, both sources hold and `pattern_out` does not change.
- R7: With `narrow_mode` = 1 captured, for pattern word D the output is `pattern_out[13:0]` = D[15:2] + D[1] and `pattern_out[15:14]` = 0.
- R8: When D[15:2] = 0x1FFF and D[1] = 1 the 14-bit result is held at 0x1FFF. As a result, the 14-bit ramp shows 0x1FFF for 6 consecutive samples and 0x2000 for 2.
- R9: A rounding carry out of 0x3FFF (for example D = 0xFFFF or 0xFFFE) wraps the 14-bit result to 0x0000.
- R10: `pattern_sel` and `narrow_mode` are sampled only on a trigger edge. A change on them at any other time does not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Advances the active sources by one sample |
| trigger | input | 1 | Reseeds both sources and captures the configuration |
| pattern_sel | input | 1 | 0 = pseudo-random sequence, 1 = ramp (captured on trigger) |
| narrow_mode | input | 1 | 0 = 16-bit output, 1 = rounded 14-bit output (captured on trigger) |
| pattern_out | output | 16 | Current pattern word; in 14-bit mode it is right-aligned with upper bits zero |

## Verification
The bench runs the 14-bit ramp through the positive limit. A design that truncates instead of rounding shifts every code boundary by two samples. A design that rounds but does not clamp prints 0x2000 where 0x1FFF is expected. It also checks that the seed 0xFFFF and the word 0xFFFE round to 0x0000 in 14-bit mode, which catches a clamp placed on the wrong side. A 300-sample run of the pseudo-random source is compared against an independent model, which exposes wrong taps or a wrong shift direction. The bench also confirms that a trigger arriving together with `sample_en` still seeds the sources, and that changes on the select inputs between triggers have no effect.

// File: rtl/tpg_pkg.sv
// Package: shared widths, tap positions and the source-select encoding
// for the converter test pattern generator. Modules take these as
// parameter defaults so one edit changes the whole block.
package tpg_pkg;

    localparam int LFSR_W    = 23;   // shift register length
    localparam int TAP_HI    = 22;   // feedback tap for x^23
    localparam int TAP_LO    = 17;   // feedback tap for x^18
    localparam int WORD_W    = 16;   // full pattern word
    localparam int NARROW_W  = 14;   // reduced output width

    typedef enum logic {
        PAT_PRBS = 1'b0,
        PAT_RAMP = 1'b1
    } pat_sel_e;

endpackage

// File: rtl/tpg_lfsr.sv
// Module: tpg_lfsr
// Fibonacci shift register that moves toward its MSB on each step.
// The new bit 0 is the XOR of bits TAP_HI and TAP_LO.
// seed_load has priority over step and sets every bit to 1.
// Assumes TAP_HI and TAP_LO are distinct and both below W.
module tpg_lfsr #(
    parameter int W      = tpg_pkg::LFSR_W,
    parameter int TAP_HI = tpg_pkg::TAP_HI,
    parameter int TAP_LO = tpg_pkg::TAP_LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_load,
    input  logic         step,
    output logic [W-1:0] state
);

    localparam logic [W-1:0] SEED = {W{1'b1}};

    logic feedback;

    // Feedback bit from the two taps
    always_comb begin
        feedback = state[TAP_HI] ^ state[TAP_LO];
    end

    // Reseed on reset or trigger, otherwise shift on each enabled sample
    always_ff @(posedge clk) begin
        if (!rst_n || seed_load) begin
            state <= SEED;
        end else if (step) begin
            state <= {state[W-2:0], feedback};
        end
    end

endmodule

// File: rtl/tpg_ramp.sv
// Module: tpg_ramp
// Free-running up counter that wraps modulo 2**W. restart clears it
// and takes priority over step.
module tpg_ramp #(
    parameter int W = tpg_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    // Clear on reset or trigger, otherwise count enabled samples
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (step) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/tpg_round.sv
// Module: tpg_round
// Reduces an IN_W-bit two's-complement word to OUT_W bits. The kept
// bits get the highest discarded bit added to them. If that sum would
// cross positive full scale, the result stays at positive full scale.
// A carry out of all-ones (the negative side, -0.5 LSB) wraps to zero,
// which is correct two's-complement rounding. Purely combinational.
// Assumes OUT_W <= IN_W.
module tpg_round #(
    parameter int IN_W  = tpg_pkg::WORD_W,
    parameter int OUT_W = tpg_pkg::NARROW_W
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    localparam int DROP = IN_W - OUT_W;
    localparam logic [OUT_W-1:0] POS_FULL = {1'b0, {(OUT_W-1){1'b1}}};

    generate
        if (DROP == 0) begin : g_pass
            // No bits discarded: pass the word through
            always_comb begin
                dout = din;
            end
        end else begin : g_round
            logic [OUT_W-1:0] kept;
            logic             half;
            logic [OUT_W-1:0] summed;

            // Split the word and add the rounding bit
            always_comb begin
                kept   = din[IN_W-1:DROP];
                half   = din[DROP-1];
                summed = kept + {{(OUT_W-1){1'b0}}, half};
            end

            // Saturate at positive full scale, else take the wrapped sum
            always_comb begin
                if (half && (kept == POS_FULL)) begin
                    dout = POS_FULL;
                end else begin
                    dout = summed;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/conv_test_pattern_gen.sv
// Module: conv_test_pattern_gen
// Per-sample test pattern source for a converter output path.
// A trigger reseeds the shift register, clears the ramp and captures
// the source select and width. The selected 16-bit word goes out as is,
// or rounded to NARROW_W bits, right-aligned with zero upper bits.
// The output is combinational from registered state, so it shows the
// new value in the cycle after the edge that changed that state.
module conv_test_pattern_gen #(
    parameter int LFSR_W   = tpg_pkg::LFSR_W,
    parameter int TAP_HI   = tpg_pkg::TAP_HI,
    parameter int TAP_LO   = tpg_pkg::TAP_LO,
    parameter int WORD_W   = tpg_pkg::WORD_W,
    parameter int NARROW_W = tpg_pkg::NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              trigger,
    input  logic              pattern_sel,
    input  logic              narrow_mode,
    output logic [WORD_W-1:0] pattern_out
);

    import tpg_pkg::*;

    localparam int PAD_W = WORD_W - NARROW_W;

    logic [LFSR_W-1:0]   lfsr_state;
    logic [WORD_W-1:0]   ramp_count;
    logic [WORD_W-1:0]   raw_word;
    logic [NARROW_W-1:0] rounded;
    logic                advance;
    pat_sel_e            sel_q;
    logic                narrow_q;

    // A trigger wins over a sample strobe in the same cycle
    always_comb begin
        advance = sample_en & ~trigger;
    end

    // Capture the configuration only when a trigger arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= PAT_PRBS;
            narrow_q <= 1'b0;
        end else if (trigger) begin
            sel_q    <= pat_sel_e'(pattern_sel);
            narrow_q <= narrow_mode;
        end
    end

    tpg_lfsr #(
        .W      (LFSR_W),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (trigger),
        .step      (advance),
        .state     (lfsr_state)
    );

    tpg_ramp #(
        .W (WORD_W)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (trigger),
        .step    (advance),
        .count   (ramp_count)
    );

    // Pick the active source
    always_comb begin
        if (sel_q == PAT_RAMP) begin
            raw_word = ramp_count;
        end else begin
            raw_word = lfsr_state[WORD_W-1:0];
        end
    end

    tpg_round #(
        .IN_W  (WORD_W),
        .OUT_W (NARROW_W)
    ) u_round (
        .din  (raw_word),
        .dout (rounded)
    );

    // Format for the captured width
    generate
        if (PAD_W == 0) begin : g_same_width
            always_comb begin
                pattern_out = narrow_q ? rounded : raw_word;
            end
        end else begin : g_padded
            always_comb begin
                pattern_out = narrow_q ? {{PAD_W{1'b0}}, rounded} : raw_word;
            end
        end
    endgenerate

endmodule

// File: rtl/tpg_checker.sv
// Module: tpg_checker
// Temporal checks on the pattern generator, bound to every instance of
// the top. It looks at the ports and at the state registers between
// the submodules. Sized for the default 16/14-bit configuration.
module tpg_checker #(
    parameter int LFSR_W   = tpg_pkg::LFSR_W,
    parameter int TAP_HI   = tpg_pkg::TAP_HI,
    parameter int TAP_LO   = tpg_pkg::TAP_LO,
    parameter int WORD_W   = tpg_pkg::WORD_W,
    parameter int NARROW_W = tpg_pkg::NARROW_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic              trigger,
    input logic              pattern_sel,
    input logic              narrow_mode,
    input logic [WORD_W-1:0] pattern_out,
    input logic [LFSR_W-1:0] lfsr_state,
    input logic [WORD_W-1:0] ramp_count,
    input logic              sel_q,
    input logic              narrow_q
);

    localparam int DROP = WORD_W - NARROW_W;
    localparam logic [WORD_W-1:0] NARROW_MAX = WORD_W'((1 << (NARROW_W - 1)) - 1);
    localparam logic [WORD_W-1:0] RAMP_TOP   = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_HALF   = {{(WORD_W-1){1'b1}}, 1'b0};

    assert_reseed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (lfsr_state == {LFSR_W{1'b1}}) && (ramp_count == '0));

    assert_lfsr_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !trigger) |=>
            (lfsr_state == {$past(lfsr_state[LFSR_W-2:0]),
                            $past(lfsr_state[TAP_HI] ^ lfsr_state[TAP_LO])}));

    assert_ramp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !trigger) |=> (ramp_count == $past(ramp_count) + WORD_W'(1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !trigger) |=> $stable(pattern_out));

    assert_narrow_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_q |-> (pattern_out[WORD_W-1:NARROW_W] == '0));

    assert_pos_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_q && sel_q && (ramp_count[WORD_W-1:1] == RAMP_TOP[WORD_W-1:1]))
            |-> (pattern_out == NARROW_MAX));

    assert_neg_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_q && sel_q && (ramp_count == NEG_HALF)) |-> (pattern_out == '0));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !trigger |=> ($stable(sel_q) && $stable(narrow_q)));

    assert_cfg_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> ((sel_q == $past(pattern_sel)) && (narrow_q == $past(narrow_mode))));

    // Immediate check: the rounding needs at least one dropped bit here
    initial begin
        assert_drop_width_R7: assert (DROP >= 1);
    end

endmodule

bind conv_test_pattern_gen tpg_checker #(
    .LFSR_W   (LFSR_W),
    .TAP_HI   (TAP_HI),
    .TAP_LO   (TAP_LO),
    .WORD_W   (WORD_W),
    .NARROW_W (NARROW_W)
) u_tpg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .trigger     (trigger),
    .pattern_sel (pattern_sel),
    .narrow_mode (narrow_mode),
    .pattern_out (pattern_out),
    .lfsr_state  (lfsr_state),
    .ramp_count  (ramp_count),
    .sel_q       (sel_q),
    .narrow_q    (narrow_q)
);

// File: tb/tb_conv_test_pattern_gen.sv
// Bench for conv_test_pattern_gen: a vector table walked by one loop,
// then directed tests for reset, priority, hold, clamp, wrap and a
// long run against an independent model.
module tb_conv_test_pattern_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int NVEC       = 13;

    // Vector layout: {sel, narrow, steps[15:0], expected[15:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 16'd0,    16'hFFFF},   // R2 R4 seed word
        {1'b0, 1'b0, 16'd1,    16'hFFFE},   // R3 first feedback bit is 0
        {1'b0, 1'b0, 16'd5,    16'hFFE0},   // R3 R4
        {1'b0, 1'b1, 16'd0,    16'h0000},   // R9 0xFFFF rounds to 0
        {1'b0, 1'b1, 16'd5,    16'h3FF8},   // R7 0xFFE0
        {1'b0, 1'b1, 16'd3,    16'h3FFE},   // R7 0xFFF8
        {1'b0, 1'b1, 16'd2,    16'h3FFF},   // R7 0xFFFC
        {1'b1, 1'b0, 16'd0,    16'h0000},   // R2 ramp restart
        {1'b1, 1'b0, 16'd1234, 16'h04D2},   // R5
        {1'b1, 1'b1, 16'd1,    16'h0000},   // R7 D=1
        {1'b1, 1'b1, 16'd2,    16'h0001},   // R7 D=2 rounds up
        {1'b1, 1'b1, 16'd6,    16'h0002},   // R7 D=6
        {1'b1, 1'b1, 16'd9,    16'h0002}    // R7 D=9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic        trigger = 1'b0;
    logic        pattern_sel = 1'b0;
    logic        narrow_mode = 1'b0;
    logic [15:0] pattern_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    conv_test_pattern_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en   (sample_en),
        .trigger     (trigger),
        .pattern_sel (pattern_sel),
        .narrow_mode (narrow_mode),
        .pattern_out (pattern_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model: one step of x^23 + x^18 + 1, shifting toward the MSB
    function automatic logic [22:0] model_step(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    // Model: 16 to 14 bit rounding with positive saturation
    function automatic logic [15:0] model_narrow(input logic [15:0] d);
        int v;
        v = int'(d[15:2]) + int'(d[1]);
        if (d[15:2] == 14'h1FFF && d[1]) v = 'h1FFF;
        return 16'(v & 'h3FFF);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fire(input logic sel, input logic narrow);
        @(negedge clk);
        trigger     = 1'b1;
        pattern_sel = sel;
        narrow_mode = narrow;
        @(negedge clk);
        trigger = 1'b0;
        #1;
    endtask

    task automatic advance(input int n);
        if (n > 0) begin
            sample_en = 1'b1;
            repeat (n) @(negedge clk);
            sample_en = 1'b0;
        end
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset word", pattern_out, 16'hFFFF);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            fire(VEC[i][33], VEC[i][32]);
            advance(int'(VEC[i][31:16]));
            check($sformatf("R2/R4/R5/R7 vector %0d", i), pattern_out, VEC[i][15:0]);
        end

        // R6 hold with no strobe
        fire(1'b1, 1'b0);
        advance(7);
        repeat (5) @(negedge clk);
        #1;
        check("R6 hold", pattern_out, 16'h0007);

        // R2 trigger wins over sample_en
        @(negedge clk);
        sample_en = 1'b1;
        trigger = 1'b1;
        pattern_sel = 1'b1;
        narrow_mode = 1'b0;
        @(negedge clk);
        trigger = 1'b0;
        sample_en = 1'b0;
        #1;
        check("R2 trigger priority", pattern_out, 16'h0000);

        // R10 select inputs ignored between triggers
        @(negedge clk);
        pattern_sel = 1'b0;
        narrow_mode = 1'b1;
        advance(3);
        check("R10 config held", pattern_out, 16'h0003);

        // R8 clamp near positive full scale on the 14-bit ramp
        begin
            logic [15:0] exp_run [12] = '{16'h1FFE, 16'h1FFE, 16'h1FFF, 16'h1FFF,
                                          16'h1FFF, 16'h1FFF, 16'h1FFF, 16'h1FFF,
                                          16'h2000, 16'h2000, 16'h2001, 16'h2001};
            fire(1'b1, 1'b1);
            advance(16'h7FF8);
            for (int k = 0; k < 12; k++) begin
                check($sformatf("R8 ramp clamp step %0d", k), pattern_out, exp_run[k]);
                advance(1);
            end
        end

        // R3 R4 R7 long pseudo-random run against the model, both widths
        for (int m = 0; m < 2; m++) begin
            logic [22:0] s;
            logic [15:0] e;
            int bad;
            s = '1;
            bad = 0;
            fire(1'b0, m[0]);
            for (int k = 0; k < 300; k++) begin
                e = m[0] ? model_narrow(s[15:0]) : s[15:0];
                if (pattern_out !== e && bad == 0) begin
                    bad = 1;
                    check($sformatf("R3/R4/R7 prbs mode %0d step %0d", m, k), pattern_out, e);
                end
                advance(1);
                s = model_step(s);
            end
            if (bad == 0) check("R3/R4/R7 prbs run", 16'h0, 16'h0);
        end

        // R5 ramp wrap after a full period in 16-bit width
        fire(1'b1, 1'b0);
        advance(65535);
        check("R5 ramp top", pattern_out, 16'hFFFF);
        advance(1);
        check("R5 ramp wrap", pattern_out, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule